// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block resolves data hazards for a five-stage in-order 32-bit pipeline that has pipeline registers after fetch, decode, execute and memory. It looks at the register numbers and control bits of the instructions in decode, execute, memory and write-back. From these it picks the sources for the two ALU operand muxes and for the two operand muxes of the equality comparator. That comparator resolves conditional branches in decode.

Branches and jumps have one delay slot, and the instruction in that slot always executes. The unit therefore never flushes anything. When no forwarding path can supply a value in time, it freezes the program counter and the fetch/decode register, and it turns the decode/execute control bits into a bubble.

The register file writes in the first half of a cycle. A value that is in write-back is therefore already visible to a decode-stage read, and the branch comparator needs no path from write-back.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When the memory-stage instruction writes a nonzero register that is not loaded from memory, and that register equals an ALU source of the execute-stage instruction, the select for that operand is 2'b10. This holds even if write-back also matches.
- R2: When only the write-back instruction writes a nonzero register that matches an ALU source in execute, the select for that operand is 2'b01.
- R3: Register 0 is never forwarded. A source of register 0 never causes a stall. The select stays 2'b00, the branch selects stay 0 and the hold signals stay 0.
- R4: With no matching enabled writer, the ALU select is 2'b00 (register file). A destination match whose write enable is low has no effect. After reset with idle inputs, every output is 0.
- R5: A load in execute whose destination matches a decode source that the decode instruction marks as used raises `pc_hold`, `ifid_hold` and `idex_bubble` together in that cycle. If that source is marked unused, none of the three is raised.
- R6: A branch in decode takes an operand from the memory-stage result (branch select 1) when a non-load writer in memory matches that operand. A non-branch instruction in decode gets branch select 0.
- R7: A branch in decode stalls when an operand is written by any writer in execute, or by a load in memory. A load therefore gives two stall cycles and an ALU instruction gives one. The branch then proceeds once the load reaches write-back.
- R8: A jump in decode never raises any stall signal, whatever the other stages hold.
- R9: A writer in write-back neither stalls a branch in decode nor forwards to it. Both branch selects stay 0 and all holds stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs | input | 5 | First source register in decode |
| id_rt | input | 5 | Second source register in decode |
| id_rs_used | input | 1 | Decode instruction reads id_rs as an operand |
| id_rt_used | input | 1 | Decode instruction reads id_rt as an operand |
| id_is_branch | input | 1 | Decode holds a conditional branch |
| id_is_jump | input | 1 | Decode holds a jump |
| ex_rs | input | 5 | First source register in execute |
| ex_rt | input | 5 | Second source register in execute |
| ex_rd | input | 5 | Destination register in execute |
| ex_reg_write | input | 1 | Execute instruction writes a register |
| ex_mem_read | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination register in memory stage |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| mem_mem_read | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | 5 | Destination register in write-back |
| wb_reg_write | input | 1 | Write-back instruction writes a register |
| fwd_a_sel | output | 2 | ALU operand A source: 00 file, 01 write-back, 10 memory stage |
| fwd_b_sel | output | 2 | ALU operand B source, same encoding |
| br_a_fwd | output | 1 | Comparator operand A from memory-stage result |
| br_b_fwd | output | 1 | Comparator operand B from memory-stage result |
| pc_hold | output | 1 | Freeze program counter |
| ifid_hold | output | 1 | Freeze fetch/decode register |
| idex_bubble | output | 1 | Zero decode/execute control bits |

## Verification
The bench drives the case where both later stages write the same register. A design with inverted priority would hand the ALU the stale write-back value. It steps a load through execute, memory and write-back under a waiting branch. A design that stalls only once would compare against a value that is not yet loaded, and one that stalls in write-back would waste a cycle. It also places register 0 and writers with write enable low in every stage, which catches a design that forwards garbage into the zero register. It sets up hazard-like fields behind a jump, where a wrong design would stall. Finally it covers an unused source that matches a load destination, where a wrong design would stall for no reason.

// File: rtl/hfu_pkg.sv
package hfu_pkg;
  localparam int REG_AW = 5;
  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_WB    = 2'b01,
    SEL_EXMEM = 2'b10
  } fwd_sel_e;

  function automatic logic reg_hit(input logic [REG_AW-1:0] src,
                                   input logic [REG_AW-1:0] dst,
                                   input logic              wen);
    return wen && (dst != '0) && (dst == src);
  endfunction
endpackage

// File: rtl/hfu_rst_sync.sv
module hfu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/hfu_alu_fwd.sv
module hfu_alu_fwd
  import hfu_pkg::*;
#(
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_load,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output fwd_sel_e      sel
);
  logic mem_hit;
  logic wb_hit;

  always_comb begin
    mem_hit = reg_hit(src, mem_rd, mem_we) && !mem_load;
    wb_hit  = reg_hit(src, wb_rd, wb_we);
    if (mem_hit)     sel = SEL_EXMEM;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_RF;
  end

  // R1: a nonload memory-stage writer outranks write-back
  p_exmem_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_load && mem_rd == src && src != '0) |-> (sel == SEL_EXMEM));

  // R3: register zero is never a forwarding target
  p_zero_never_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == SEL_RF));
endmodule

// File: rtl/hfu_br_fwd.sv
module hfu_br_fwd
  import hfu_pkg::*;
#(
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_branch,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_load,
  output logic          take_mem
);
  always_comb
    take_mem = is_branch && !mem_load && reg_hit(src, mem_rd, mem_we);

  // R6: only a branch uses the comparator forwarding path
  p_branch_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_branch |-> !take_mem);
endmodule

// File: rtl/hfu_stall_ctl.sv
module hfu_stall_ctl
  import hfu_pkg::*;
#(
  parameter int AW = REG_AW,
  parameter int NS = NUM_SRC
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NS-1:0][AW-1:0]  id_src,
  input  logic [NS-1:0]          id_used,
  input  logic                   id_branch,
  input  logic                   id_jump,
  input  logic [AW-1:0]          ex_rd,
  input  logic                   ex_we,
  input  logic                   ex_load,
  input  logic [AW-1:0]          mem_rd,
  input  logic                   mem_we,
  input  logic                   mem_load,
  output logic                   stall
);
  logic load_use;
  logic br_wait;

  always_comb begin
    load_use = 1'b0;
    br_wait  = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (id_used[i] && ex_load && reg_hit(id_src[i], ex_rd, ex_we))
        load_use = 1'b1;
      if (id_branch && (reg_hit(id_src[i], ex_rd, ex_we) ||
                        (mem_load && reg_hit(id_src[i], mem_rd, mem_we))))
        br_wait = 1'b1;
    end
    stall = (load_use || br_wait) && !id_jump;
  end

  // R8: a jump never stalls
  p_jump_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    id_jump |-> !stall);

  // R7: a load in memory still blocks a branch that reads its result
  p_branch_load_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_branch && !id_jump && mem_we && mem_load && mem_rd != '0 &&
     mem_rd == id_src[0]) |-> stall);
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hfu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] id_rs,
  input  logic [4:0] id_rt,
  input  logic       id_rs_used,
  input  logic       id_rt_used,
  input  logic       id_is_branch,
  input  logic       id_is_jump,
  input  logic [4:0] ex_rs,
  input  logic [4:0] ex_rt,
  input  logic [4:0] ex_rd,
  input  logic       ex_reg_write,
  input  logic       ex_mem_read,
  input  logic [4:0] mem_rd,
  input  logic       mem_reg_write,
  input  logic       mem_mem_read,
  input  logic [4:0] wb_rd,
  input  logic       wb_reg_write,
  output logic [1:0] fwd_a_sel,
  output logic [1:0] fwd_b_sel,
  output logic       br_a_fwd,
  output logic       br_b_fwd,
  output logic       pc_hold,
  output logic       ifid_hold,
  output logic       idex_bubble
);
  logic rst_n_s;
  logic [NUM_SRC-1:0][REG_AW-1:0] id_src;
  logic [NUM_SRC-1:0][REG_AW-1:0] ex_src;
  logic [NUM_SRC-1:0]             id_used;
  fwd_sel_e [NUM_SRC-1:0]         alu_sel;
  logic [NUM_SRC-1:0]             br_sel;
  logic                           stall;

  assign id_src  = {id_rt, id_rs};
  assign ex_src  = {ex_rt, ex_rs};
  assign id_used = {id_rt_used, id_rs_used};

  hfu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hfu_alu_fwd #(.AW(REG_AW)) u_alu (
      .clk(clk), .rst_n(rst_n_s), .src(ex_src[g]),
      .mem_rd(mem_rd), .mem_we(mem_reg_write), .mem_load(mem_mem_read),
      .wb_rd(wb_rd), .wb_we(wb_reg_write), .sel(alu_sel[g])
    );
    hfu_br_fwd #(.AW(REG_AW)) u_br (
      .clk(clk), .rst_n(rst_n_s), .is_branch(id_is_branch), .src(id_src[g]),
      .mem_rd(mem_rd), .mem_we(mem_reg_write), .mem_load(mem_mem_read),
      .take_mem(br_sel[g])
    );
  end

  hfu_stall_ctl #(.AW(REG_AW), .NS(NUM_SRC)) u_stall (
    .clk(clk), .rst_n(rst_n_s), .id_src(id_src), .id_used(id_used),
    .id_branch(id_is_branch), .id_jump(id_is_jump),
    .ex_rd(ex_rd), .ex_we(ex_reg_write), .ex_load(ex_mem_read),
    .mem_rd(mem_rd), .mem_we(mem_reg_write), .mem_load(mem_mem_read),
    .stall(stall)
  );

  assign fwd_a_sel   = alu_sel[0];
  assign fwd_b_sel   = alu_sel[1];
  assign br_a_fwd    = br_sel[0];
  assign br_b_fwd    = br_sel[1];
  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;

  // R5: a load feeding a used source freezes the front end
  p_load_use_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!id_is_jump && ex_mem_read && ex_reg_write && ex_rd != 5'd0 &&
     id_rs_used && id_rs == ex_rd) |-> (pc_hold && idex_bubble));

  // R2: write-back alone supplies operand A
  p_wb_only_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wb_reg_write && wb_rd != 5'd0 && wb_rd == ex_rs && !mem_reg_write)
      |-> (fwd_a_sel == 2'b01));

  // R9: write-back never stalls a branch
  p_wb_no_branch_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ex_reg_write && !mem_reg_write) |-> !pc_hold);
endmodule

// File: tb/hazard_fwd_unit_test.sv
module hazard_fwd_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic id_rs_used, id_rt_used, id_is_branch, id_is_jump;
  logic ex_reg_write, ex_mem_read, mem_reg_write, mem_mem_read, wb_reg_write;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic br_a_fwd, br_b_fwd, pc_hold, ifid_hold, idex_bubble;
  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_fwd_unit uut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    id_rs = 0; id_rt = 0; id_rs_used = 0; id_rt_used = 0;
    id_is_branch = 0; id_is_jump = 0;
    ex_rs = 0; ex_rt = 0; ex_rd = 0; ex_reg_write = 0; ex_mem_read = 0;
    mem_rd = 0; mem_reg_write = 0; mem_mem_read = 0;
    wb_rd = 0; wb_reg_write = 0;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic holds(input string req, input int exp);
    check(req, pc_hold, exp);
    check(req, ifid_hold, exp);
    check(req, idex_bubble, exp);
  endtask

  task automatic t_reset();
    idle(); step();
    check("R4 reset a", fwd_a_sel, 0);
    check("R4 reset b", fwd_b_sel, 0);
    check("R4 reset br", {br_a_fwd, br_b_fwd}, 0);
    holds("R4 reset hold", 0);
  endtask

  task automatic t_exmem();
    idle(); @(negedge clk);
    ex_rs = 3; ex_rt = 7; mem_rd = 3; mem_reg_write = 1; wb_rd = 3; wb_reg_write = 1;
    step();
    check("R1 priority a", fwd_a_sel, 2);
    check("R1 b untouched", fwd_b_sel, 0);
    idle(); @(negedge clk);
    ex_rs = 9; ex_rt = 9; mem_rd = 9; mem_reg_write = 1;
    step();
    check("R1 both a", fwd_a_sel, 2);
    check("R1 both b", fwd_b_sel, 2);
  endtask

  task automatic t_wb();
    idle(); @(negedge clk);
    ex_rs = 4; ex_rt = 12; wb_rd = 12; wb_reg_write = 1; mem_rd = 4; mem_reg_write = 0;
    step();
    check("R2 wb b", fwd_b_sel, 1);
    check("R4 mem we low a", fwd_a_sel, 0);
  endtask

  task automatic t_zero();
    idle(); @(negedge clk);
    mem_rd = 0; mem_reg_write = 1; wb_rd = 0; wb_reg_write = 1;
    ex_rd = 0; ex_reg_write = 1; ex_mem_read = 1;
    id_rs_used = 1; id_rt_used = 1; id_is_branch = 1;
    step();
    check("R3 zero a", fwd_a_sel, 0);
    check("R3 zero br", {br_a_fwd, br_b_fwd}, 0);
    holds("R3 zero hold", 0);
  endtask

  task automatic t_no_we();
    idle(); @(negedge clk);
    ex_rs = 5; ex_rt = 5; mem_rd = 5; wb_rd = 5;
    step();
    check("R4 no we a", fwd_a_sel, 0);
    check("R4 no we b", fwd_b_sel, 0);
  endtask

  task automatic t_load_use();
    idle(); @(negedge clk);
    id_rt = 6; id_rt_used = 1; ex_rd = 6; ex_reg_write = 1; ex_mem_read = 1;
    step();
    holds("R5 load use", 1);
    id_rt_used = 0;
    step();
    holds("R5 unused source", 0);
    id_rt_used = 1; ex_mem_read = 0;
    step();
    holds("R5 alu in ex no stall", 0);
  endtask

  task automatic t_branch_fwd();
    idle(); @(negedge clk);
    id_is_branch = 1; id_rs = 8; id_rt = 2; mem_rd = 8; mem_reg_write = 1;
    step();
    check("R6 br a", br_a_fwd, 1);
    check("R6 br b", br_b_fwd, 0);
    holds("R6 no stall", 0);
    id_is_branch = 0;
    step();
    check("R6 non branch", br_a_fwd, 0);
  endtask

  task automatic t_branch_stall();
    idle(); @(negedge clk);
    id_is_branch = 1; id_rs = 10; id_rt = 11;
    ex_rd = 11; ex_reg_write = 1;
    step();
    holds("R7 alu in ex", 1);
    ex_reg_write = 0; mem_rd = 11; mem_reg_write = 1;
    step();
    holds("R7 alu done", 0);
    check("R7 alu forward", br_b_fwd, 1);
    idle(); @(negedge clk);
    id_is_branch = 1; id_rs = 10; ex_rd = 10; ex_reg_write = 1; ex_mem_read = 1;
    step();
    holds("R7 load in ex", 1);
    ex_rd = 0; ex_reg_write = 0; ex_mem_read = 0;
    mem_rd = 10; mem_reg_write = 1; mem_mem_read = 1;
    step();
    holds("R7 load in mem", 1);
    check("R7 no fwd of load", br_a_fwd, 0);
    mem_rd = 0; mem_reg_write = 0; mem_mem_read = 0; wb_rd = 10; wb_reg_write = 1;
    step();
    holds("R9 load in wb", 0);
    check("R9 no br fwd", br_a_fwd, 0);
  endtask

  task automatic t_jump();
    idle(); @(negedge clk);
    id_is_jump = 1; id_rs = 13; id_rs_used = 1;
    ex_rd = 13; ex_reg_write = 1; ex_mem_read = 1;
    step();
    holds("R8 jump", 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_exmem();
    t_wb();
    t_zero();
    t_no_we();
    t_load_use();
    t_branch_fwd();
    t_branch_stall();
    t_jump();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule